// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Load/Store Processor Core

This block is a small in-order processor. It has eight 16-bit general registers, a 16-bit program counter and four condition flags: negative, zero, carry and overflow. Instructions and data share one word-addressed memory. The core reaches that memory through a single synchronous port. The core drives an address, plus a write enable with write data. Read data comes back on the clock after the address is presented.

Each instruction runs as a sequence of states:

- fetch;
- latch the instruction word, incrementing the program counter;
- execute;
- an extra write-back state, for memory loads only.

The instruction set covers the following:

- eight conditional branch forms, including signed less/greater and carry;
- add, and, and not;
- load and store, either relative to the program counter or relative to a base register;
- load-effective-address;
- call by offset or by register;
- jump and return;
- a trap instruction.

The trap instruction stops the core, or pulses a one-cycle output strobe. The strobe carries either a line-feed code or the value of a register.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted, `halted`, `out_strobe` and `mem_we` are 0. Reset clears the program counter, all eight registers and all flags, so the first fetch after reset uses address 0.
- R2: Opcode 1 adds the register in bits 8:6 to a second operand and writes the sum to the register in bits 11:9. The second operand is the register in bits 2:0, or the sign-extended bits 4:0 when bit 5 is 1. The add sets n (bit 15 of the result), z (result is zero), c (carry out of bit 15) and v (signed overflow).
- R3: Opcode 5 (and) and opcode 9 (not, which inverts the register in bits 8:6) write their result to the register in bits 11:9. They update only n and z, and leave c and v unchanged. Opcode 5 selects its second operand with bit 5, in the same way as opcode 1.
- R4: Opcode 0 adds the sign-extended bits 8:0 to the incremented PC when the condition in bits 11:9 holds. The conditions are: 0 z; 1 not z; 2 n; 3 n equal to z; 4 n differs from v; 5 n equal to v and not z; 6 c; 7 always.
- R5: Opcode 2 loads, and opcode 3 stores, the word at the incremented PC plus the sign-extended bits 8:0. The register in bits 11:9 is the destination of the load and the source of the store.
- R6: Opcode 6 loads, and opcode 7 stores, the word at the address formed by the register in bits 8:6 plus the sign-extended bits 5:0.
- R7: Opcode 14 writes the incremented PC plus the sign-extended bits 8:0 into the register in bits 11:9. Neither this opcode nor any load changes a flag.
- R8: Opcode 4 writes the incremented PC to r7. With bit 11 set, it jumps to the incremented PC plus the sign-extended bits 10:0. Otherwise it jumps to the register in bits 8:6 plus the sign-extended bits 5:0, using the value that register held before r7 was written.
- R9: Opcode 12 jumps to the register in bits 8:6 plus the sign-extended bits 5:0. With base 7 it returns through r7.
- R10: Opcode 15 reads its vector from bits 4:0. Vector 1 gives a one-cycle `out_strobe` with `out_kind`=0 and `out_data`=0x000A. Vector 2 gives a one-cycle strobe with `out_kind`=1 and `out_data` equal to the register in bits 11:9.
- R11: Trap vector 0 raises `halted` and keeps it high until reset. While halted, the core stops fetching, holds `mem_addr`, never writes memory and gives no strobe.
- R12: Opcodes 8, 10, 11 and 13 change no register, no flag and no memory word; they only advance the PC. The same holds for trap vectors 3 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for the memory port |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| out_strobe | output | 1 | One-cycle pulse from trap vectors 1 and 2 |
| out_kind | output | 1 | 0 = line-feed code, 1 = register value |
| out_data | output | 16 | Data that goes with the strobe |
| halted | output | 1 | High once the halt trap has executed |

## Verification
The call-by-register form can name r7 as its base. In that case, the link write to r7 and the read of r7 as the jump base fall in the same execute cycle. The bench sets up exactly this case: it makes a call by offset, which loads r7, and follows it with a call by register through r7. It then checks two things against values worked out by hand. The next instruction executed must sit at the old r7 plus the offset. The new r7 must hold the address after the second call.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

   // opcode values (bits 15:12 of the instruction word)
   localparam logic [3:0] OPC_BRANCH = 4'd0;
   localparam logic [3:0] OPC_ADD    = 4'd1;
   localparam logic [3:0] OPC_LDPC   = 4'd2;
   localparam logic [3:0] OPC_STPC   = 4'd3;
   localparam logic [3:0] OPC_CALL   = 4'd4;
   localparam logic [3:0] OPC_AND    = 4'd5;
   localparam logic [3:0] OPC_LDB    = 4'd6;
   localparam logic [3:0] OPC_STB    = 4'd7;
   localparam logic [3:0] OPC_NOT    = 4'd9;
   localparam logic [3:0] OPC_JUMP   = 4'd12;
   localparam logic [3:0] OPC_ADDR   = 4'd14;
   localparam logic [3:0] OPC_TRAP   = 4'd15;

   typedef enum logic [2:0] {
      ST_FETCH, ST_LATCH, ST_EXEC, ST_LOADWB, ST_HALT
   } core_state_e;

   typedef enum logic [1:0] {
      ALU_SUM, ALU_AND, ALU_INV
   } alu_sel_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cc_flags_t;

endpackage

// File: rtl/mc16_decode.sv
module mc16_decode
   import mc16_pkg::*;
#(
   parameter int XLEN = 16
) (
   input  logic [XLEN-1:0] instr,
   output logic [3:0]      opc,
   output logic [2:0]      fld_d,
   output logic [2:0]      fld_a,
   output logic [2:0]      fld_b,
   output logic            use_imm,
   output logic            call_rel,
   output logic [4:0]      vector,
   output logic [XLEN-1:0] sx5,
   output logic [XLEN-1:0] sx6,
   output logic [XLEN-1:0] sx9,
   output logic [XLEN-1:0] sx11
);
   assign opc      = instr[15:12];
   assign fld_d    = instr[11:9];
   assign fld_a    = instr[8:6];
   assign fld_b    = instr[2:0];
   assign use_imm  = instr[5];
   assign call_rel = instr[11];
   assign vector   = instr[4:0];
   assign sx5      = {{(XLEN-5){instr[4]}},   instr[4:0]};
   assign sx6      = {{(XLEN-6){instr[5]}},   instr[5:0]};
   assign sx9      = {{(XLEN-9){instr[8]}},   instr[8:0]};
   assign sx11     = {{(XLEN-11){instr[10]}}, instr[10:0]};
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int XLEN  = 16,
   parameter int NREGS = 8,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_idx,
   input  logic [XLEN-1:0] wr_val,
   input  logic [AW-1:0]   rd_idx_a,
   input  logic [AW-1:0]   rd_idx_b,
   output logic [XLEN-1:0] rd_val_a,
   output logic [XLEN-1:0] rd_val_b
);
   logic [XLEN-1:0] bank [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_idx == AW'(g))
            q <= wr_val;
      end
      assign bank[g] = q;
   end

   assign rd_val_a = bank[rd_idx_a];
   assign rd_val_b = bank[rd_idx_b];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
#(
   parameter int XLEN = 16
) (
   input  alu_sel_e        sel,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] res,
   output cc_flags_t       cc
);
   localparam int MSB = XLEN - 1;
   logic [XLEN:0] wide;

   assign wide = {1'b0, opa} + {1'b0, opb};

   always_comb begin
      cc = '0;
      unique case (sel)
         ALU_SUM: begin
            res  = wide[MSB:0];
            cc.c = wide[XLEN];
            cc.v = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
         end
         ALU_AND: res = opa & opb;
         default: res = ~opa;
      endcase
      cc.n = res[MSB];
      cc.z = (res == '0);
   end
endmodule

// File: rtl/mc16_cond.sv
module mc16_cond
   import mc16_pkg::*;
(
   input  logic [2:0] code,
   input  cc_flags_t  cc,
   output logic       take
);
   always_comb begin
      unique case (code)
         3'd0: take = cc.z;
         3'd1: take = !cc.z;
         3'd2: take = cc.n;
         3'd3: take = (cc.n == cc.z);
         3'd4: take = (cc.n != cc.v);
         3'd5: take = (cc.n == cc.v) && !cc.z;
         3'd6: take = cc.c;
         default: take = 1'b1;
      endcase
   end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter int              XLEN     = 16,
   parameter int              NREGS    = 8,
   parameter int              LINK_REG = 7,
   parameter logic [XLEN-1:0] LF_CODE  = 'h000A
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            out_strobe,
   output logic            out_kind,
   output logic [XLEN-1:0] out_data,
   output logic            halted
);
   localparam int AW = $clog2(NREGS);

   if (XLEN != 16) begin : g_bad_xlen
      $error("mc16_core: instruction encoding fixes XLEN at 16");
   end
   if (NREGS != 8) begin : g_bad_nregs
      $error("mc16_core: register fields are 3 bits, NREGS must be 8");
   end
   if (LINK_REG < 0 || LINK_REG >= NREGS) begin : g_bad_link
      $error("mc16_core: LINK_REG out of range");
   end

   core_state_e     state;
   logic [XLEN-1:0] pc, ir;
   cc_flags_t       flags;

   logic [3:0]      opc;
   logic [2:0]      fld_d, fld_a, fld_b;
   logic            use_imm, call_rel;
   logic [4:0]      vector;
   logic [XLEN-1:0] sx5, sx6, sx9, sx11;

   mc16_decode #(.XLEN(XLEN)) u_dec (
      .instr(ir), .opc(opc), .fld_d(fld_d), .fld_a(fld_a), .fld_b(fld_b),
      .use_imm(use_imm), .call_rel(call_rel), .vector(vector),
      .sx5(sx5), .sx6(sx6), .sx9(sx9), .sx11(sx11)
   );

   logic            rf_we;
   logic [AW-1:0]   rf_widx, idx_b;
   logic [XLEN-1:0] rf_wval, val_a, val_b;

   assign idx_b = (opc == OPC_STPC || opc == OPC_STB || opc == OPC_TRAP)
                  ? AW'(fld_d) : AW'(fld_b);

   mc16_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_idx(rf_widx),
      .wr_val(rf_wval), .rd_idx_a(AW'(fld_a)), .rd_idx_b(idx_b),
      .rd_val_a(val_a), .rd_val_b(val_b)
   );

   alu_sel_e        alu_sel;
   logic [XLEN-1:0] alu_res;
   cc_flags_t       alu_cc;

   assign alu_sel = (opc == OPC_ADD) ? ALU_SUM :
                    (opc == OPC_AND) ? ALU_AND : ALU_INV;

   mc16_alu #(.XLEN(XLEN)) u_alu (
      .sel(alu_sel), .opa(val_a), .opb(use_imm ? sx5 : val_b),
      .res(alu_res), .cc(alu_cc)
   );

   logic br_take;
   mc16_cond u_cond (.code(fld_d), .cc(flags), .take(br_take));

   logic [XLEN-1:0] ea_pc, ea_base;
   assign ea_pc   = pc + sx9;
   assign ea_base = val_a + sx6;

   // memory port and register write-back, decided by state
   always_comb begin
      mem_addr  = pc;
      mem_we    = 1'b0;
      mem_wdata = val_b;
      rf_we     = 1'b0;
      rf_widx   = AW'(fld_d);
      rf_wval   = alu_res;
      if (state == ST_EXEC) begin
         unique case (opc)
            OPC_ADD, OPC_AND, OPC_NOT: rf_we = 1'b1;
            OPC_ADDR: begin rf_we = 1'b1; rf_wval = ea_pc; end
            OPC_CALL: begin
               rf_we   = 1'b1;
               rf_widx = AW'(LINK_REG);
               rf_wval = pc;
            end
            OPC_LDPC: mem_addr = ea_pc;
            OPC_LDB:  mem_addr = ea_base;
            OPC_STPC: begin mem_addr = ea_pc;   mem_we = 1'b1; end
            OPC_STB:  begin mem_addr = ea_base; mem_we = 1'b1; end
            default: ;
         endcase
      end else if (state == ST_LOADWB) begin
         rf_we   = 1'b1;
         rf_wval = mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_FETCH;
         pc         <= '0;
         ir         <= '0;
         flags      <= '0;
         out_strobe <= 1'b0;
         out_kind   <= 1'b0;
         out_data   <= '0;
      end else begin
         out_strobe <= 1'b0;
         unique case (state)
            ST_FETCH: state <= ST_LATCH;
            ST_LATCH: begin
               ir    <= mem_rdata;
               pc    <= pc + XLEN'(1);
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               state <= ST_FETCH;
               unique case (opc)
                  OPC_BRANCH: if (br_take) pc <= ea_pc;
                  OPC_ADD:    flags <= alu_cc;
                  OPC_AND, OPC_NOT: begin
                     flags.n <= alu_cc.n;
                     flags.z <= alu_cc.z;
                  end
                  OPC_CALL:   pc <= call_rel ? pc + sx11 : ea_base;
                  OPC_JUMP:   pc <= ea_base;
                  OPC_LDPC, OPC_LDB: state <= ST_LOADWB;
                  OPC_TRAP: begin
                     if (vector == 5'd0) begin
                        state <= ST_HALT;
                     end else if (vector == 5'd1) begin
                        out_strobe <= 1'b1;
                        out_kind   <= 1'b0;
                        out_data   <= LF_CODE;
                     end else if (vector == 5'd2) begin
                        out_strobe <= 1'b1;
                        out_kind   <= 1'b1;
                        out_data   <= val_b;
                     end
                  end
                  default: ;
               endcase
            end
            ST_LOADWB: state <= ST_FETCH;
            default:   state <= ST_HALT;
         endcase
      end
   end

   assign halted = (state == ST_HALT);
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk #(
   parameter int XLEN = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            halted,
   input logic            out_strobe,
   input logic            out_kind,
   input logic [XLEN-1:0] out_data,
   input logic            mem_we,
   input logic [XLEN-1:0] mem_addr
);
   p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_halt_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_we && !out_strobe));

   p_halt_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && $past(halted)) |-> $stable(mem_addr));

   p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe |=> !out_strobe);

   p_linefeed_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_strobe && !out_kind) |-> (out_data == XLEN'(10)));

   p_store_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
endmodule

bind mc16_core mc16_core_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .halted(halted), .out_strobe(out_strobe),
   .out_kind(out_kind), .out_data(out_data), .mem_we(mem_we),
   .mem_addr(mem_addr)
);

// File: tb/tb_mc16_core.sv
`timescale 1ns/1ps
module tb_mc16_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr, mem_wdata, out_data;
   logic [15:0] mem_rdata = '0;
   logic        mem_we, out_strobe, out_kind, halted;

   always #5 clk = ~clk;

   mc16_core dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_strobe(out_strobe),
      .out_kind(out_kind), .out_data(out_data), .halted(halted)
   );

   // memory model: 256 words, synchronous read
   logic [15:0] mem [0:255];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   int          nchk = 0, nfail = 0;
   int          pp;
   int          xcnt;
   logic [16:0] xval [0:63];
   string       xreq [0:63];
   int          ocnt;
   logic [16:0] oval [0:63];

   always @(negedge clk) begin
      if (!rst_n) ocnt = 0;
      else if (out_strobe) begin
         if (ocnt < 64) oval[ocnt] = {out_kind, out_data};
         ocnt++;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // instruction encoders
   function automatic logic [15:0] e_br(logic [2:0] cc, logic [8:0] o);
      return {4'h0, cc, o};
   endfunction
   function automatic logic [15:0] e_add(logic [2:0] d, logic [2:0] a, logic [2:0] b);
      return {4'h1, d, a, 3'b000, b};
   endfunction
   function automatic logic [15:0] e_addi(logic [2:0] d, logic [2:0] a, logic [4:0] i);
      return {4'h1, d, a, 1'b1, i};
   endfunction
   function automatic logic [15:0] e_and(logic [2:0] d, logic [2:0] a, logic [2:0] b);
      return {4'h5, d, a, 3'b000, b};
   endfunction
   function automatic logic [15:0] e_andi(logic [2:0] d, logic [2:0] a, logic [4:0] i);
      return {4'h5, d, a, 1'b1, i};
   endfunction
   function automatic logic [15:0] e_not(logic [2:0] d, logic [2:0] a);
      return {4'h9, d, a, 6'h3F};
   endfunction
   function automatic logic [15:0] e_ldb(logic [2:0] d, logic [2:0] b, logic [5:0] o);
      return {4'h6, d, b, o};
   endfunction
   function automatic logic [15:0] e_stb(logic [2:0] s, logic [2:0] b, logic [5:0] o);
      return {4'h7, s, b, o};
   endfunction
   function automatic logic [15:0] e_call(logic [10:0] o);
      return {4'h4, 1'b1, o};
   endfunction
   function automatic logic [15:0] e_callr(logic [2:0] b, logic [5:0] o);
      return {4'h4, 3'b000, b, o};
   endfunction
   function automatic logic [15:0] e_jmp(logic [2:0] b, logic [5:0] o);
      return {4'hC, 3'b000, b, o};
   endfunction
   function automatic logic [15:0] e_trap(logic [2:0] r, logic [4:0] v);
      return {4'hF, r, 4'b0000, v};
   endfunction

   task automatic begin_prog();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      pp = 0;
      xcnt = 0;
   endtask
   task automatic put(logic [15:0] w);
      mem[pp[7:0]] = w;
      pp++;
   endtask
   task automatic put_pcrel(logic [3:0] op, logic [2:0] r, int tgt);
      int off = tgt - (pp + 1);
      put({op, r, off[8:0]});
   endtask
   task automatic expv(string r, logic k, logic [15:0] d);
      xval[xcnt] = {k, d};
      xreq[xcnt] = r;
      xcnt++;
   endtask
   // branch over a line-feed trap, then emit marker r0 (=0)
   task automatic probe(logic [2:0] cc, bit taken, string r);
      put(e_br(cc, 9'd1));
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd0, 5'd2));
      if (!taken) expv(r, 1'b0, 16'h000A);
      expv(r, 1'b1, 16'h0000);
   endtask

   task automatic run_prog(string name);
      int cyc = 0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset halted", 32'(halted), 0);
      check("R1 reset strobe", 32'(out_strobe), 0);
      check("R1 reset we", 32'(mem_we), 0);
      rst_n = 1'b1;
      #1;
      check("R1 first fetch address", 32'(mem_addr), 0);
      while (!halted && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      check({name, " R11 reached halt"}, 32'(halted), 1);
      check({name, " output count"}, ocnt, xcnt);
      for (int i = 0; i < xcnt && i < ocnt && i < 64; i++)
         check({name, " ", xreq[i]}, 32'(oval[i]), 32'(xval[i]));
   endtask

   task automatic t_reset();
      begin_prog();
      for (int r = 0; r < 8; r++) begin
         put(e_trap(3'(r), 5'd2));
         expv("R1 register cleared", 1'b1, 16'h0000);
      end
      put(e_trap(3'd0, 5'd0));
      run_prog("reset");
   endtask

   task automatic t_add();
      begin_prog();
      mem[8'h80] = 16'h7FFF;
      put(e_addi(3'd1, 3'd0, 5'd5));
      put(e_addi(3'd2, 3'd0, 5'h1D));          // -3
      put(e_add(3'd3, 3'd1, 3'd2));            // 2, c=1
      put(e_trap(3'd3, 5'd2)); expv("R2 add sum", 1'b1, 16'h0002);
      probe(3'd0, 0, "R4 z clear");
      probe(3'd2, 0, "R4 n clear");
      probe(3'd6, 1, "R2 R4 carry set");
      probe(3'd4, 0, "R4 lt false");
      probe(3'd5, 1, "R4 gt true");
      put_pcrel(4'h2, 3'd4, 8'h80);            // r4 = 7FFF
      put(e_addi(3'd5, 3'd4, 5'd1));           // 8000, n=1 v=1 c=0
      put(e_trap(3'd5, 5'd2)); expv("R2 overflow sum", 1'b1, 16'h8000);
      probe(3'd2, 1, "R2 R4 n set");
      probe(3'd4, 0, "R2 R4 lt with v");
      probe(3'd6, 0, "R2 R4 carry clear");
      probe(3'd5, 1, "R2 R4 gt with v");
      probe(3'd3, 0, "R4 n==z false");
      put(e_addi(3'd6, 3'd1, 5'h1B));          // 5-5 = 0, z=1 c=1
      probe(3'd0, 1, "R2 R4 z set");
      probe(3'd1, 0, "R4 nz false");
      probe(3'd6, 1, "R2 R4 carry on zero");
      probe(3'd3, 0, "R4 n==z zero");
      probe(3'd7, 1, "R4 always");
      put(e_addi(3'd1, 3'd0, 5'd3));
      put(e_addi(3'd1, 3'd1, 5'h1F));          // loop: r1--
      put(e_br(3'd1, 9'h1FE));                 // back two
      put(e_trap(3'd1, 5'd2)); expv("R4 backward loop", 1'b1, 16'h0000);
      put(e_trap(3'd0, 5'd0));
      run_prog("add");
   endtask

   task automatic t_logic();
      begin_prog();
      put(e_addi(3'd1, 3'd0, 5'h1F));          // FFFF
      put(e_addi(3'd2, 3'd1, 5'd1));           // 0, c=1 v=0
      put(e_and(3'd3, 3'd1, 3'd1));            // FFFF
      probe(3'd6, 1, "R3 and keeps c");
      probe(3'd2, 1, "R3 and sets n");
      probe(3'd0, 0, "R3 and clears z");
      probe(3'd4, 1, "R3 and keeps v");
      put(e_andi(3'd4, 3'd1, 5'd0));
      probe(3'd0, 1, "R3 and zero");
      probe(3'd6, 1, "R3 and zero keeps c");
      put(e_not(3'd5, 3'd4));
      probe(3'd2, 1, "R3 not sets n");
      put(e_trap(3'd5, 5'd2)); expv("R3 not value", 1'b1, 16'hFFFF);
      put(e_andi(3'd6, 3'd1, 5'd10));
      put(e_trap(3'd6, 5'd2)); expv("R3 and imm", 1'b1, 16'h000A);
      put(e_trap(3'd3, 5'd2)); expv("R3 and reg", 1'b1, 16'hFFFF);
      put(e_trap(3'd0, 5'd0));
      run_prog("logic");
   endtask

   task automatic t_mem();
      begin_prog();
      mem[8'h80] = 16'h1234;
      put(e_addi(3'd5, 3'd0, 5'd0));           // z=1
      put_pcrel(4'h2, 3'd1, 8'h80);
      probe(3'd0, 1, "R7 load keeps z");
      put_pcrel(4'h3, 3'd1, 8'h81);
      put_pcrel(4'hE, 3'd2, 8'h81);
      probe(3'd0, 1, "R7 lea keeps z");
      put(e_trap(3'd2, 5'd2)); expv("R7 lea value", 1'b1, 16'h0081);
      put(e_ldb(3'd3, 3'd2, 6'd0));
      probe(3'd0, 1, "R7 base load keeps z");
      put(e_stb(3'd3, 3'd2, 6'd1));
      put(e_ldb(3'd4, 3'd2, 6'h3F));           // -1 -> 0x80
      put(e_ldb(3'd6, 3'd2, 6'd1));
      put(e_trap(3'd3, 5'd2)); expv("R5 R6 stored then loaded", 1'b1, 16'h1234);
      put(e_trap(3'd4, 5'd2)); expv("R6 negative offset", 1'b1, 16'h1234);
      put(e_trap(3'd6, 5'd2)); expv("R6 base store", 1'b1, 16'h1234);
      put(e_trap(3'd0, 5'd0));
      run_prog("mem");
      check("R5 pc-relative store word", 32'(mem[8'h81]), 32'h1234);
      check("R6 base store word", 32'(mem[8'h82]), 32'h1234);
   endtask

   task automatic t_ctrl();
      begin_prog();
      put(e_call(11'd2));                      // 0: r7=1 -> 3
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd7, 5'd2)); expv("R8 link by offset", 1'b1, 16'd1);
      put(e_callr(3'd7, 6'd7));                // 4: old r7 1 +7 -> 8, r7=5
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd7, 5'd2)); expv("R8 call through r7", 1'b1, 16'd5);
      put(e_lea_at9());                        // 9: r1 = 13
      put(e_jmp(3'd1, 6'd2));                  // 10: -> 15
      for (int i = 11; i < 15; i++) put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd1, 5'd2)); expv("R9 jump target", 1'b1, 16'd13);
      put(e_call(11'd3));                      // 16: r7=17 -> 20
      put(e_trap(3'd0, 5'd0));                 // 17: halt on return
      put(e_trap(3'd0, 5'd1));
      put(e_trap(3'd0, 5'd1));
      put(e_addi(3'd2, 3'd0, 5'd9));           // 20
      put(e_trap(3'd2, 5'd2)); expv("R9 before return", 1'b1, 16'd9);
      put(e_jmp(3'd7, 6'd0));                  // 22: return to 17
      run_prog("ctrl");
   endtask
   function automatic logic [15:0] e_lea_at9();
      return {4'hE, 3'd1, 9'd3};
   endfunction

   task automatic t_trap();
      logic [15:0] a0;
      int          o0;
      bit          ok = 1'b1;
      begin_prog();
      put(e_addi(3'd3, 3'd0, 5'd7));
      put(e_trap(3'd0, 5'd1)); expv("R10 line feed", 1'b0, 16'h000A);
      put(e_trap(3'd3, 5'd2)); expv("R10 register value", 1'b1, 16'h0007);
      put(16'h8FFF); put(16'hA123); put(16'hB7C0); put(16'hD5E5);
      put(e_trap(3'd3, 5'd3));
      put(e_trap(3'd3, 5'd2)); expv("R12 unused opcodes", 1'b1, 16'h0007);
      put(e_trap(3'd7, 5'd2)); expv("R12 r7 untouched", 1'b1, 16'h0000);
      probe(3'd0, 0, "R12 flags untouched");
      put(e_trap(3'd0, 5'd0));
      run_prog("trap");
      a0 = mem_addr;
      o0 = ocnt;
      repeat (20) begin
         @(negedge clk);
         if (!halted || mem_we || mem_addr !== a0) ok = 1'b0;
      end
      check("R11 halt holds quiet", 32'(ok), 1);
      check("R11 no strobe after halt", ocnt, o0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      t_reset();
      t_add();
      t_logic();
      t_mem();
      t_ctrl();
      t_trap();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule